// File: doc/BRIEF.md
# Direction-Switched Byte FIFO with Quantity and Status Readout

This block is a byte queue of parameterised depth (64 by default) placed between a parallel port and a DMA engine. A single direction input sets its meaning. In receive direction the quantity readout gives the number of bytes waiting in storage. In transmit direction it gives the number of free slots. Between the storage array and the consumer sit two holding stages. Bytes move forward through them on their own whenever the next stage is free. Each stage carries a tag bit alongside its byte, and the consumer always takes bytes from the second stage.

An eight-bit status readout sums up the queue and the holding pipeline. It also carries a sticky timeout flag, which is raised when the stale input goes from low to high. In transmit direction the flag rises at once. In receive direction it waits until the queue has drained and the DMA side reports idle. The CPU clears the flag by changing the level of a clear-toggle input or by issuing a FIFO reset. A FIFO reset also empties the storage and both holding stages.

Top module: `bfifo_top`

## Requirements
- R1: After device reset or a FIFO reset, the quantity reads 0 when `dirTx`=0 and DEPTH (64) when `dirTx`=1, with the empty flag set and the full flag clear.
- R2: With `dirTx`=0 the quantity equals the number of bytes in the storage array. Bytes held in the two holding stages are not counted.
- R3: With `dirTx`=1 the quantity equals DEPTH minus the number of bytes in the storage array.
- R4: A write while the array holds DEPTH bytes is dropped and leaves the count unchanged. `rdEn` while stage 2 is empty has no effect.
- R5: A write accepted in the same cycle as a transfer from the array into stage 1 leaves the count unchanged.
- R6: A byte moves from the array to stage 1, and from stage 1 to stage 2, in any cycle where the receiving stage is empty or is being emptied. Order and tag are preserved. `rdValid`, `rdData` and `rdTag` present stage 2, and `rdEn` with `rdValid` removes it.
- R7: The status bits, from bit 7 down to bit 0, are: full, empty, timeout, holding tag (a valid stage holds a tagged byte), holding data (either stage valid), the stale input, one-char (exactly one stage valid), and a reserved bit that reads 0.
- R8: With `dirTx`=1, a low-to-high change of `staleIn` sets the timeout flag at the following clock edge.
- R9: With `dirTx`=0, a stale rise is remembered. Timeout sets only at an edge where the array is empty and `dmaIdle` is high.
- R10: Timeout stays set until `clrToggle` differs from its level at the previous edge, or until `fifoClr` is asserted. A clear wins over a simultaneous set.
- R11: `fifoClr` empties both holding stages, which clears the holding data, holding tag and one-char flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low device reset |
| dirTx | input | 1 | 0 = receive, 1 = transmit |
| fifoClr | input | 1 | FIFO reset strobe |
| wrEn | input | 1 | Write request |
| wrData | input | 8 | Write byte |
| wrTag | input | 1 | Tag bit stored with the byte |
| rdEn | input | 1 | Take the byte in holding stage 2 |
| rdData | output | 8 | Byte in holding stage 2 |
| rdTag | output | 1 | Tag of holding stage 2 |
| rdValid | output | 1 | Holding stage 2 occupied |
| staleIn | input | 1 | Stale condition |
| dmaIdle | input | 1 | DMA side has no cycle in progress |
| clrToggle | input | 1 | Timeout clear; each level change clears |
| quantity | output | 7 | Stored count or free space |
| status | output | 8 | Status flags |

## Verification
The hardest state to reach is a deferred receive timeout. It needs a stale rise while the array still holds bytes and DMA is busy, followed by a drain during which the flag must stay low, and only then an idle DMA side. The stimulus gets there in three steps. It first parks bytes in the array with reads held off. It then raises stale with `dmaIdle` low and drains with reads on. Finally it raises `dmaIdle`. A behavioural queue model is compared against every output on every cycle, so count and flag errors on the way are caught as well.

// File: rtl/bfifo_pkg.sv
package bfifo_pkg;
  typedef struct packed {
    logic push;     // byte accepted into storage
    logic fifoPop;  // storage head moves into holding stage 1
    logic moveH1;   // stage 1 moves into stage 2
    logic popOut;   // consumer takes stage 2
    logic flush;    // FIFO reset
  } fifoStrobes_t;
endpackage

// File: rtl/bfifo_ctrl.sv
module bfifo_ctrl
  import bfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dirTx,
  input  logic          fifoClr,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          staleIn,
  input  logic          dmaIdle,
  input  logic          clrToggle,
  input  logic          h1Valid,
  input  logic          h2Valid,
  output fifoStrobes_t  strobes,
  output logic [CW-1:0] occ,
  output logic          timeout
);
  logic isFull, isEmpty, h2Free, h1Free;
  logic stalePrev, clrPrev, pending;
  logic staleRise, clrHit;

  assign isFull  = (occ == CW'(DEPTH));
  assign isEmpty = (occ == '0);

  always_comb begin
    strobes.flush   = fifoClr;
    strobes.popOut  = rdEn & h2Valid;
    h2Free          = ~h2Valid | strobes.popOut;
    strobes.moveH1  = h1Valid & h2Free;
    h1Free          = ~h1Valid | strobes.moveH1;
    strobes.fifoPop = ~isEmpty & h1Free;
    strobes.push    = wrEn & ~isFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN || fifoClr) begin
      occ <= '0;
    end else begin
      occ <= occ + CW'(strobes.push) - CW'(strobes.fifoPop);
    end
  end

  assign staleRise = staleIn & ~stalePrev;
  assign clrHit    = clrToggle ^ clrPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeout   <= 1'b0;
      pending   <= 1'b0;
      stalePrev <= 1'b0;
      clrPrev   <= 1'b0;
    end else begin
      stalePrev <= staleIn;
      clrPrev   <= clrToggle;
      if (fifoClr || clrHit) begin
        timeout <= 1'b0;
        pending <= 1'b0;
      end else if (dirTx) begin
        pending <= 1'b0;
        if (staleRise) timeout <= 1'b1;
      end else if ((pending || staleRise) && isEmpty && dmaIdle) begin
        timeout <= 1'b1;
        pending <= 1'b0;
      end else if (staleRise) begin
        pending <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bfifo_dpath.sv
module bfifo_dpath
  import bfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStrobes_t  strobes,
  input  logic [DW-1:0] wrData,
  input  logic          wrTag,
  output logic          h1Valid,
  output logic          h1Tag,
  output logic          h2Valid,
  output logic          h2Tag,
  output logic [DW-1:0] h2Data
);
  logic [DW:0]   mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [DW-1:0] h1Data;

  always_ff @(posedge clk) begin
    if (strobes.push && !strobes.flush) mem[wrPtr] <= {wrTag, wrData};
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.flush) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      h1Valid <= 1'b0;
      h2Valid <= 1'b0;
      h1Tag   <= 1'b0;
      h2Tag   <= 1'b0;
      h1Data  <= '0;
      h2Data  <= '0;
    end else begin
      if (strobes.push)    wrPtr <= wrPtr + 1'b1;
      if (strobes.fifoPop) rdPtr <= rdPtr + 1'b1;
      if (strobes.moveH1) begin
        h2Data  <= h1Data;
        h2Tag   <= h1Tag;
        h2Valid <= 1'b1;
      end else if (strobes.popOut) begin
        h2Valid <= 1'b0;
      end
      if (strobes.fifoPop) begin
        {h1Tag, h1Data} <= mem[rdPtr];
        h1Valid         <= 1'b1;
      end else if (strobes.moveH1) begin
        h1Valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bfifo_top.sv
module bfifo_top
  import bfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dirTx,
  input  logic          fifoClr,
  input  logic          wrEn,
  input  logic [DW-1:0] wrData,
  input  logic          wrTag,
  input  logic          rdEn,
  output logic [DW-1:0] rdData,
  output logic          rdTag,
  output logic          rdValid,
  input  logic          staleIn,
  input  logic          dmaIdle,
  input  logic          clrToggle,
  output logic [CW-1:0] quantity,
  output logic [7:0]    status
);
  fifoStrobes_t  strobes;
  logic [CW-1:0] occ;
  logic          timeout, h1Valid, h1Tag, h2Valid, h2Tag;

  bfifo_ctrl #(.DEPTH(DEPTH)) ctrlI (
    .clk(clk), .rstN(rstN), .dirTx(dirTx), .fifoClr(fifoClr),
    .wrEn(wrEn), .rdEn(rdEn), .staleIn(staleIn), .dmaIdle(dmaIdle),
    .clrToggle(clrToggle), .h1Valid(h1Valid), .h2Valid(h2Valid),
    .strobes(strobes), .occ(occ), .timeout(timeout)
  );

  bfifo_dpath #(.DEPTH(DEPTH), .DW(DW)) dpathI (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .wrTag(wrTag), .h1Valid(h1Valid), .h1Tag(h1Tag), .h2Valid(h2Valid),
    .h2Tag(h2Tag), .h2Data(rdData)
  );

  assign rdTag    = h2Tag;
  assign rdValid  = h2Valid;
  assign quantity = dirTx ? (CW'(DEPTH) - occ) : occ;

  assign status = {
    occ == CW'(DEPTH),
    occ == '0,
    timeout,
    (h1Valid & h1Tag) | (h2Valid & h2Tag),
    h1Valid | h2Valid,
    staleIn,
    h1Valid ^ h2Valid,
    1'b0
  };
endmodule

// File: rtl/bfifo_chk.sv
module bfifo_chk #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          dirTx,
  input logic          fifoClr,
  input logic          staleIn,
  input logic          dmaIdle,
  input logic          clrToggle,
  input logic          rdValid,
  input logic [CW-1:0] quantity,
  input logic [7:0]    status
);
  // R2
  quantity_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    quantity <= CW'(DEPTH));

  // R7
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(status[7] && status[6]));

  // R1
  clear_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoClr |=> (quantity == (dirTx ? CW'(DEPTH) : CW'(0))) && status[6]);

  // R11
  clear_holding_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoClr |=> !status[3] && !status[4] && !status[1] && !rdValid);

  // R6
  out_stage_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> status[3]);

  // R10
  timeout_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    status[5] && !fifoClr && $stable(clrToggle) |=> status[5]);

  // R8
  tx_stale_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    dirTx && $rose(staleIn) && !fifoClr && $stable(clrToggle) |=> status[5]);

  // R9
  rx_defer_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dirTx && !status[5] && (!status[6] || !dmaIdle) |=> !status[5]);
endmodule

bind bfifo_top bfifo_chk #(.DEPTH(DEPTH)) chkI (
  .clk(clk), .rstN(rstN), .dirTx(dirTx), .fifoClr(fifoClr),
  .staleIn(staleIn), .dmaIdle(dmaIdle), .clrToggle(clrToggle),
  .rdValid(rdValid), .quantity(quantity), .status(status)
);

// File: tb/tb_bfifo_top.sv
`timescale 1ns/1ps
module tb_bfifo_top;
  localparam int DEPTH = 64;

  logic clk = 0;
  logic rstN = 0, dirTx = 0, fifoClr = 0, wrEn = 0, wrTag = 0, rdEn = 0;
  logic staleIn = 0, dmaIdle = 1, clrToggle = 0;
  logic [7:0] wrData = 0;
  logic [7:0] rdData;
  logic rdTag, rdValid;
  logic [6:0] quantity;
  logic [7:0] status;

  int checks = 0, fails = 0;

  // behavioural model state
  int q[$];             // bit 8 = tag, bits 7:0 = data
  bit m1v, m2v;
  int m1, m2;
  bit mTo, mPend, mStaleP, mClrP;

  always #2 clk = ~clk;

  bfifo_top dut (
    .clk(clk), .rstN(rstN), .dirTx(dirTx), .fifoClr(fifoClr),
    .wrEn(wrEn), .wrData(wrData), .wrTag(wrTag), .rdEn(rdEn),
    .rdData(rdData), .rdTag(rdTag), .rdValid(rdValid),
    .staleIn(staleIn), .dmaIdle(dmaIdle), .clrToggle(clrToggle),
    .quantity(quantity), .status(status)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    bit popOut, h2Free, mv, h1Free, fpop, push, rise, clr, emptyNow;
    int head;
    if (!rstN) begin
      q.delete(); m1v = 0; m2v = 0; mTo = 0; mPend = 0; mStaleP = 0; mClrP = 0;
      return;
    end
    emptyNow = (q.size() == 0);
    popOut = rdEn && m2v;
    h2Free = !m2v || popOut;
    mv     = m1v && h2Free;
    h1Free = !m1v || mv;
    fpop   = !emptyNow && h1Free;
    push   = wrEn && (q.size() < DEPTH);
    rise   = staleIn && !mStaleP;
    clr    = (clrToggle != mClrP);
    if (fifoClr) begin
      q.delete(); m1v = 0; m2v = 0;
    end else begin
      if (mv) begin m2 = m1; m2v = 1; end
      else if (popOut) m2v = 0;
      if (fpop) begin head = q.pop_front(); m1 = head; m1v = 1; end
      else if (mv) m1v = 0;
      if (push) q.push_back({23'd0, wrTag, wrData});
    end
    if (fifoClr || clr) begin mTo = 0; mPend = 0; end
    else if (dirTx) begin mPend = 0; if (rise) mTo = 1; end
    else if ((mPend || rise) && emptyNow && dmaIdle) begin mTo = 1; mPend = 0; end
    else if (rise) mPend = 1;
    mStaleP = staleIn;
    mClrP   = clrToggle;
  endtask

  task automatic compareAll();
    int sz, expQ, expS;
    bit t1, t2;
    sz   = q.size();
    expQ = dirTx ? DEPTH - sz : sz;
    t1 = m1v && m1[8];
    t2 = m2v && m2[8];
    expS = {24'd0, sz == DEPTH, sz == 0, mTo, t1 | t2, m1v | m2v, staleIn, m1v ^ m2v, 1'b0};
    check(dirTx ? "R3 quantity" : "R2 quantity", quantity, expQ);
    check("R7 status", status, expS);
    check("R6 rdValid", rdValid, m2v);
    if (m2v) begin
      check("R6 rdData", rdData, m2 & 8'hff);
      check("R6 rdTag", rdTag, m2[8]);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    modelStep();
    #1;
    compareAll();
  endtask

  task automatic cycN(int n);
    for (int i = 0; i < n; i++) begin
      cyc();
      if (wrEn) begin wrData = wrData + 1; wrTag = wrData[0]; end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cycN(3);
    rstN = 1;
    cyc();
    // R1 reset state in receive direction
    check("R1 rx reset quantity", quantity, 0);
    check("R1 rx reset status", status, 8'h40);

    // fill beyond capacity with no reads
    wrEn = 1; wrData = 8'h10; wrTag = 0;
    cycN(5);
    // R6: two bytes parked in holding stages, not counted (R2)
    check("R6 holding data set", status[3], 1);
    check("R2 excludes holding", quantity, 3);
    cycN(70);
    wrEn = 0;
    check("R4 full flag", status[7], 1);
    check("R2 full count", quantity, DEPTH);
    wrEn = 1;
    cyc();
    wrEn = 0;
    check("R4 write to full dropped", quantity, DEPTH);

    // R3 transmit view of a full array
    dirTx = 1;
    cyc();
    check("R3 tx full quantity", quantity, 0);

    // R5 read and write together
    rdEn = 1; wrEn = 1;
    cycN(1);
    check("R5 first pop", quantity, 1);
    cycN(6);
    check("R5 push plus pop", quantity, 1);
    wrEn = 0;
    cycN(80);
    check("R3 tx empty quantity", quantity, DEPTH);
    check("R4 read on empty ignored", rdValid, 0);
    rdEn = 0;

    // R11 / R1: FIFO reset with bytes in holding stages
    wrEn = 1; wrTag = 1;
    cyc();
    wrEn = 0;
    cycN(4);
    check("R11 tag before clear", status[4], 1);
    fifoClr = 1; cyc(); fifoClr = 0;
    check("R11 holding cleared", status & 8'h1a, 0);
    check("R1 tx clear quantity", quantity, DEPTH);

    // R8 transmit timeout
    staleIn = 1;
    cyc();
    check("R8 tx timeout set", status[5], 1);
    staleIn = 0;
    cycN(5);
    check("R10 timeout sticky", status[5], 1);
    clrToggle = 1;
    cyc();
    check("R10 toggle clears", status[5], 0);
    cycN(3);
    staleIn = 1; cyc(); staleIn = 0;
    check("R8 second set", status[5], 1);
    clrToggle = 0;
    cyc();
    check("R10 falling toggle clears", status[5], 0);

    // R9 deferred receive timeout
    dirTx = 0;
    fifoClr = 1; cyc(); fifoClr = 0;
    check("R1 rx clear quantity", quantity, 0);
    wrEn = 1; cycN(6); wrEn = 0;
    dmaIdle = 0;
    staleIn = 1; cyc();
    check("R9 no set while data stored", status[5], 0);
    rdEn = 1;
    cycN(12);
    check("R9 drained but DMA busy", status[5], 0);
    check("R9 drained", status[6], 1);
    dmaIdle = 1;
    cyc();
    check("R9 set when idle and empty", status[5], 1);
    rdEn = 0;
    cycN(3);
    fifoClr = 1; cyc(); fifoClr = 0;
    check("R10 FIFO reset clears timeout", status[5], 0);
    staleIn = 0;

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      wrEn = (i % 3) != 0;
      rdEn = (i % 5) < 2;
      dirTx = (i / 100) % 2;
      staleIn = (i % 37) > 30;
      dmaIdle = (i % 11) > 3;
      if (i % 53 == 0) clrToggle = ~clrToggle;
      fifoClr = (i % 97) == 96;
      cycN(1);
    end
    fifoClr = 0; wrEn = 0; rdEn = 0;
    cyc();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule